// File: doc/BRIEF.md
# Byte-Wide SPI Master Shifter

This block moves one byte at a time over a serial peripheral link, acting as the clock master. A processor-side write strobe hands it a byte. An idle engine then runs a complete exchange of eight bits on its serial clock, data-out and data-in pins. While the byte goes out on the data-out pin, the byte on the data-in pin is shifted in. The received byte lands in a separate receive buffer, and the read-data port always shows that buffer.

Three static controls set the format of each exchange. The clock polarity control sets the idle level of the serial clock. The clock phase control sets which edge of each clock cycle launches data and which edge captures it. The bit-order control picks most-significant-bit-first or least-significant-bit-first shifting. A divider input sets the serial clock half-period in system clocks. Two sticky flags report a finished byte and a write that arrived while the engine was busy. A read strobe clears both flags. The slave-select pin is not driven by this block.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, busy, done_flag, wcol_flag, mosi and rd_data are all zero, and sck equals cpol.
- R2: When wr_en is high while busy is low, busy is high from the next cycle for exactly 16×H system clocks, where H is the half-period. The serial clock makes exactly 8 full cycles, with one edge every H clocks. busy falls in the same cycle as the last edge.
- R3: Whenever busy is low, sck equals cpol. The first edge of an exchange therefore leaves the idle level.
- R4: With cpha=0, the first data bit is on mosi in the cycle after the starting write. mosi changes only on trailing (even-numbered) edges, and miso is captured on leading (odd-numbered) edges.
- R5: With cpha=1, mosi changes on leading edges, the first of these presenting the first data bit, and miso is captured on trailing edges.
- R6: With lsb_first=0, bit 7 is sent first and the first received bit becomes bit 7 of the received byte. With lsb_first=1, bit 0 goes first and the first received bit becomes bit 0.
- R7: rd_data shows the receive buffer and changes only in the cycle an exchange completes. At that point it takes the full received byte and done_flag becomes 1. Bits still being shifted in never appear on rd_data.
- R8: done_flag stays 1 until rd_en is seen. If rd_en and a completion occur in the same cycle, the flag stays set.
- R9: A write while busy is high is ignored: the byte in flight is unchanged and no new exchange starts. wcol_flag is set in the next cycle and held until rd_en. A set in the same cycle as rd_en wins.
- R10: A half_div value of 0 behaves as a half-period of 1 system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears done_flag and wcol_flag |
| rd_data | output | 8 | Receive buffer contents |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| lsb_first | input | 1 | 1: least significant bit shifted first |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Exchange in progress |
| done_flag | output | 1 | Sticky byte-complete flag |
| wcol_flag | output | 1 | Sticky write-while-busy flag |

## Verification
A bad edge counter or divider count shows up within one half-period. The serial clock toggles on the wrong system cycle, or busy is high for a different number of cycles than 16×H. A capture or launch register that is wrong shows up on mosi at the next launch edge. On the receive side it shows up on rd_data in the cycle the exchange ends. A flag that is never cleared or set is visible on the first cycle after the strobe that should have changed it. The reference model is compared against every output on every clock, so the first wrong cycle is reported directly.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done_flag,
  output logic             wcol_flag
);
  localparam int EDGES = 16;
  localparam int EW = $clog2(EDGES);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic             busy_q, sck_q, mosi_q, done_q, wcol_q;
  logic [DIV_W-1:0] div_cnt;
  logic [EW-1:0]    edge_cnt;
  logic [7:0]       tx_sr, rx_sr, rx_buf;

  wire [DIV_W-1:0] hp = (half_div == '0) ? DIV_ONE : half_div;
  wire start  = wr_en && !busy_q;
  wire tick   = busy_q && (div_cnt == hp - DIV_ONE);
  wire last   = tick && (edge_cnt == LAST_EDGE);
  wire smp    = tick && (edge_cnt[0] == cpha);
  wire launch = tick && !smp && !(!cpha && edge_cnt == LAST_EDGE);

  wire [7:0] rx_nx  = lsb_first ? {miso, rx_sr[7:1]} : {rx_sr[6:0], miso};
  wire [7:0] tx_nx  = lsb_first ? {1'b0, tx_sr[7:1]} : {tx_sr[6:0], 1'b0};
  wire       tx_bit = lsb_first ? tx_sr[0] : tx_sr[7];
  wire [7:0] wr_sh  = lsb_first ? {1'b0, wr_data[7:1]} : {wr_data[6:0], 1'b0};
  wire       wr_bit = lsb_first ? wr_data[0] : wr_data[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_buf   <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      sck_q    <= cpol;
      div_cnt  <= '0;
      edge_cnt <= '0;
      if (!cpha) begin
        mosi_q <= wr_bit;
        tx_sr  <= wr_sh;
      end else begin
        tx_sr  <= wr_data;
      end
    end else if (busy_q) begin
      if (tick) begin
        div_cnt  <= '0;
        sck_q    <= ~sck_q;
        edge_cnt <= edge_cnt + EW'(1);
      end else begin
        div_cnt  <= div_cnt + DIV_ONE;
      end
      if (smp) rx_sr <= rx_nx;
      if (launch) begin
        mosi_q <= tx_bit;
        tx_sr  <= tx_nx;
      end
      if (last) begin
        busy_q <= 1'b0;
        rx_buf <= smp ? rx_nx : rx_sr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      done_q <= last || (done_q && !rd_en);
      wcol_q <= (wr_en && busy_q) || (wcol_q && !rd_en);
    end
  end

  assign sck       = busy_q ? sck_q : cpol;
  assign mosi      = mosi_q;
  assign busy      = busy_q;
  assign rd_data   = rx_buf;
  assign done_flag = done_q;
  assign wcol_flag = wcol_q;
endmodule

module spi_byte_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic             cpol,
  input logic             cpha,
  input logic             lsb_first,
  input logic [DIV_W-1:0] half_div,
  input logic             sck,
  input logic             mosi,
  input logic             miso,
  input logic             busy,
  input logic             done_flag,
  input logic             wcol_flag
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy |=> busy);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sck == cpol);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $fell(busy));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));
  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !busy |=> !done_flag);
  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> wcol_flag);
endmodule

bind spi_byte_master spi_byte_master_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, cpol = 0, cpha = 0, lsb_first = 0, miso = 0;
  logic [7:0] wr_data = 0, half_div = 1;
  logic [7:0] rd_data;
  logic sck, mosi, busy, done_flag, wcol_flag;
  int checks = 0, fails = 0;
  bit finished = 0;

  spi_byte_master #(.DIV_W(8)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  bit m_busy, m_sck, m_mosi, m_done, m_wcol;
  int m_cnt, m_edge;
  logic [7:0] m_buf;
  bit txq[$];
  bit rxq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sck = 0; m_mosi = 0; m_done = 0; m_wcol = 0;
      m_cnt = 0; m_edge = 0; m_buf = 0; txq.delete(); rxq.delete();
    end else begin
      int hp;
      hp = (half_div == 0) ? 1 : int'(half_div);
      if (rd_en) begin m_done = 0; m_wcol = 0; end
      if (wr_en && m_busy) m_wcol = 1;
      if (wr_en && !m_busy) begin
        m_busy = 1; m_sck = cpol; m_cnt = 0; m_edge = 0;
        txq.delete(); rxq.delete();
        for (int i = 0; i < 8; i++) txq.push_back(lsb_first ? wr_data[i] : wr_data[7-i]);
        if (!cpha) m_mosi = txq.pop_front();
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == hp) begin
          bit lead, capture;
          m_cnt = 0;
          m_sck = !m_sck;
          lead = (m_edge % 2) == 0;
          capture = (lead == !cpha);
          if (capture) rxq.push_back(miso);
          else if (txq.size() > 0) m_mosi = txq.pop_front();
          m_edge++;
          if (m_edge == 16) begin
            m_busy = 0;
            for (int i = 0; i < 8; i++) m_buf[lsb_first ? i : 7-i] = rxq[i];
            m_done = 1;
          end
        end
      end
    end
  end

  // per-clock comparison and edge monitor
  bit prev_sck = 0, prev_busy = 0;
  int rises = 0;
  bit cap_q[$];

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(busy === m_busy, "R2", "busy", busy, m_busy);
      chk(sck === (m_busy ? m_sck : cpol), "R3", "sck", sck, m_busy ? m_sck : cpol);
      chk(mosi === m_mosi, "R4", "mosi", mosi, m_mosi);
      chk(rd_data === m_buf, "R7", "rd_data", rd_data, m_buf);
      chk(done_flag === m_done, "R8", "done_flag", done_flag, m_done);
      chk(wcol_flag === m_wcol, "R9", "wcol_flag", wcol_flag, m_wcol);
      if ((busy || prev_busy) && sck !== prev_sck) begin
        if (sck) rises++;
        if (sck == (cpol == cpha)) cap_q.push_back(mosi);
      end
    end
    prev_sck = sck;
    prev_busy = busy;
  end

  always @(negedge clk) miso <= 1'($urandom);

  task automatic xfer(input logic [7:0] d, input bit pol, input bit pha, input bit lsb, input int dv, input int coll);
    int hp, n;
    logic [7:0] got;
    string tag;
    hp = (dv == 0) ? 1 : dv;
    n = 0;
    @(negedge clk);
    cpol = pol; cpha = pha; lsb_first = lsb; half_div = 8'(dv);
    @(negedge clk);
    chk(sck === pol, "R3", "idle sck", sck, pol);
    cap_q.delete(); rises = 0;
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (!pha) chk(mosi === (lsb ? d[0] : d[7]), "R4", "first bit before edge", mosi, lsb ? d[0] : d[7]);
    while (busy) begin
      n++;
      if (n == coll) begin wr_data = 8'hFF; wr_en = 1; end
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    chk(n == 16*hp, dv == 0 ? "R10" : "R2", "busy cycles", n, 16*hp);
    chk(rises == 8, "R2", "sck rising edges", rises, 8);
    got = 0;
    for (int i = 0; i < 8 && i < cap_q.size(); i++) got[lsb ? i : 7-i] = cap_q[i];
    tag = lsb ? "R6" : (pha ? "R5" : "R4");
    if (coll != 0) tag = "R9";
    chk(cap_q.size() == 8 && got == d, tag, "mosi byte at capture edges", got, d);
    chk(done_flag === 1'b1, "R7", "done after byte", done_flag, 1);
    if (coll != 0) chk(wcol_flag === 1'b1, "R9", "collision flag", wcol_flag, 1);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(done_flag === 1'b0, "R8", "done cleared by read", done_flag, 0);
    chk(wcol_flag === 1'b0, "R9", "collision cleared by read", wcol_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done_flag === 0 && wcol_flag === 0, "R1", "reset flags", {busy, done_flag, wcol_flag}, 0);
    chk(rd_data === 8'h00 && mosi === 0, "R1", "reset data", {rd_data, mosi}, 0);
    chk(sck === cpol, "R1", "reset sck", sck, cpol);
    xfer(8'hA5, 0, 0, 0, 2, 0);
    xfer(8'h3C, 0, 1, 0, 1, 0);
    xfer(8'h96, 1, 0, 1, 3, 0);
    xfer(8'h71, 1, 1, 1, 0, 0);
    xfer(8'hC3, 0, 0, 0, 2, 9);
    xfer(8'h5E, 1, 1, 0, 4, 20);
    for (int k = 0; k < 8; k++)
      xfer(8'($urandom), 1'(k), 1'(k >> 1), 1'(k >> 2), k % 3, 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule